// File: doc/BRIEF.md
# Variable-Length Integer Decoder

This block pulls one compact integer field out of a byte stream. The bytes that come before the block present the next four stream bytes as a 32-bit look-ahead window, with the earliest byte in the low eight bits. The block returns the decoded 32-bit value and the number of bytes the field took up. The byte source then advances its read pointer by that count before it offers the next window.

A field is one to four bytes long. In each of the first three bytes, the top bit says whether another byte follows. The fourth byte, when a field reaches it, always ends the field and gives all eight of its bits as payload. Each request selects its own mode. Unsigned requests return the payload zero-extended. Signed requests return it sign-extended from its highest payload bit.

The decoder is a two-stage pipeline. It can take a new request on every cycle, and every result arrives exactly two cycles after its request, whatever the field length.

Top module: `varint_dec`

## Requirements
- R1: In each of the first three window bytes, bits [6:0] are payload and bit 7 is a continuation flag: 1 means another byte follows.
- R2: The first byte among the first three whose bit 7 is 0 ends the field. `out_count` equals that byte's position plus one. Bytes after it have no effect on `out_value`.
- R3: When bit 7 is set in all of the first three bytes, the field is four bytes long whatever the fourth byte's bit 7 holds. All eight bits of the fourth byte are payload, so a result is at most 29 bits wide.
- R4: Payload groups are placed little-endian. Byte 0 gives result bits [6:0], byte 1 gives [13:7], byte 2 gives [20:14] and byte 3 gives [28:21].
- R5: A request accepted while `in_valid` is high in cycle t produces `out_valid` high in cycle t+2, for every length. Requests on consecutive cycles give results on consecutive cycles. `out_valid` is low two cycles after a cycle with no request. `in_ready` stays high.
- R6: `out_count` holds a value from 1 to 4 whenever `out_valid` is high.
- R7: When `in_signed` is 0 in a request, every result bit above the field's payload is 0. Bits [31:29] are therefore always 0 in unsigned mode.
- R8: When `in_signed` is 1 in a request, the field's top payload bit is copied into every higher result bit. That bit is bit 6, 13, 20 or 28 for lengths 1 to 4.
- R9: While `rst_n` is low at a clock edge, the pipeline's valid flags clear. `out_valid` stays low until a request made after reset has had its two cycles.
- R10: The mode belongs to each request. Requests with different modes on consecutive cycles are each decoded in their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | Decoder accepts a request (always high) |
| in_signed | input | 1 | 1: signed decode, 0: unsigned decode |
| in_window | input | 32 | Next four stream bytes, earliest in bits [7:0] |
| out_valid | output | 1 | `out_value` and `out_count` are valid |
| out_value | output | 32 | Decoded, extended integer |
| out_count | output | 3 | Bytes used by the field (1 to 4) |

## Verification
A wrong length decision in the first stage shows up exactly two cycles later in two ways. `out_count` is off by at least one, and payload bits are either missing from `out_value` or taken from a byte beyond the field, which is why the bench fills those bytes with non-zero data. A mode or valid flag that gets out of step in the pipeline shows at the outputs on the very next result of a run where requests alternate, with a wrong top word or a result in the wrong cycle. A flaw in sign extension shows only when the field's top payload bit is 1, so the bench sets that bit at every field length.

// File: rtl/varint_pkg.sv
// Shared types for the variable-length integer decoder.
// Assumes nothing beyond standard SystemVerilog.
package varint_pkg;

    // Decode mode carried along with each request.
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } vmode_e;

endpackage

// File: rtl/varint_len.sv
// Field length finder: scans the continuation flags of the first
// MAX_BYTES-1 bytes and reports how many bytes the field occupies.
// Assumes the flag is the top bit of each byte and the last byte is
// always final.
module varint_len #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = 3
) (
    input  logic [BYTE_W*MAX_BYTES-1:0] window,
    output logic [CNT_W-1:0]            len
);

    // The lowest byte with a clear flag wins; default is the full length.
    always_comb begin
        len = CNT_W'(MAX_BYTES);
        for (int i = MAX_BYTES - 2; i >= 0; i--) begin
            if (!window[i*BYTE_W + BYTE_W - 1]) len = CNT_W'(i + 1);
        end
    end

endmodule

// File: rtl/varint_assemble.sv
// Payload assembler: packs the payload groups of the bytes inside the
// field little-endian, then zero- or sign-extends to OUT_W bits.
// Assumes len is in 1..MAX_BYTES and OUT_W >= the widest payload.
module varint_assemble #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = 3,
    parameter int OUT_W     = 32
) (
    input  logic [BYTE_W*MAX_BYTES-1:0] window,
    input  logic [CNT_W-1:0]            len,
    input  logic                        is_signed,
    output logic [OUT_W-1:0]            value
);

    localparam int PAY_W   = BYTE_W - 1;
    localparam int LAST_LO = PAY_W * (MAX_BYTES - 1);
    localparam int FIELD_W = LAST_LO + BYTE_W;

    logic [FIELD_W-1:0] field;
    logic [OUT_W-1:0]   field_ext;
    logic               sgn;
    int                 used_w;

    // Flagged bytes: keep only the payload bits, and only inside the field.
    for (genvar g = 0; g < MAX_BYTES - 1; g++) begin : g_grp
        assign field[g*PAY_W +: PAY_W] =
            (len > CNT_W'(g)) ? window[g*BYTE_W +: PAY_W] : '0;
    end

    // Final byte: every bit is payload, present only at full length.
    assign field[LAST_LO +: BYTE_W] =
        (len == CNT_W'(MAX_BYTES)) ? window[(MAX_BYTES-1)*BYTE_W +: BYTE_W] : '0;

    assign field_ext = OUT_W'(field);

    // Find the field's payload width and its top payload bit.
    always_comb begin
        used_w = FIELD_W;
        for (int k = 1; k < MAX_BYTES; k++) begin
            if (len == CNT_W'(k)) used_w = k * PAY_W;
        end
        sgn = field_ext[used_w - 1];
    end

    // Extend above the payload with zero or with the sign bit.
    always_comb begin
        for (int j = 0; j < OUT_W; j++) begin
            value[j] = (j < used_w) ? field_ext[j] : (is_signed & sgn);
        end
    end

endmodule

// File: rtl/varint_dec.sv
// Variable-length integer decoder, top level. Two register stages:
// stage 1 captures the request with its field length, stage 2 holds the
// assembled value and byte count. Fixed two-cycle latency, one request
// per cycle, no back-pressure. Only the valid flags are reset.
module varint_dec #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int OUT_W     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_signed,
    input  logic [BYTE_W*MAX_BYTES-1:0] in_window,
    output logic                        out_valid,
    output logic [OUT_W-1:0]            out_value,
    output logic [$clog2(MAX_BYTES+1)-1:0] out_count
);

    import varint_pkg::*;

    localparam int WIN_W = BYTE_W * MAX_BYTES;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic             s1_valid;
    logic [WIN_W-1:0] s1_window;
    logic [CNT_W-1:0] s1_len;
    vmode_e           s1_mode;
    logic [CNT_W-1:0] len_c;
    logic [OUT_W-1:0] value_c;

    // No stall source exists, so requests are always taken.
    assign in_ready = 1'b1;

    varint_len #(
        .BYTE_W   (BYTE_W),
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W)
    ) u_len (
        .window(in_window),
        .len   (len_c)
    );

    // Pipeline valid flags, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    // Stage 1 data: window, length and mode of the accepted request.
    always_ff @(posedge clk) begin
        s1_window <= in_window;
        s1_len    <= len_c;
        s1_mode   <= in_signed ? MODE_SIGNED : MODE_UNSIGNED;
    end

    varint_assemble #(
        .BYTE_W   (BYTE_W),
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W),
        .OUT_W    (OUT_W)
    ) u_asm (
        .window   (s1_window),
        .len      (s1_len),
        .is_signed(s1_mode == MODE_SIGNED),
        .value    (value_c)
    );

    // Stage 2 data: registered result and consume count.
    always_ff @(posedge clk) begin
        out_value <= value_c;
        out_count <= s1_len;
    end

endmodule

// File: rtl/varint_dec_chk.sv
// Assertion checker for varint_dec, attached by bind. Assumes the
// default geometry: 8-bit bytes, four-byte window, 32-bit result.
module varint_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_signed,
    input logic [31:0] in_window,
    input logic        out_valid,
    input logic [31:0] out_value,
    input logic [2:0]  out_count
);

    // R5: every request yields a result two cycles on.
    a_r5_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R5: no request, no result two cycles on.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R6: count within 1..4 whenever valid.
    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= 3'd1 && out_count <= 3'd4));

    // R2: a clear flag in byte 0 ends the field after one byte.
    a_r2_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_window[7]) |-> ##2 (out_count == 3'd1));

    // R3: three set flags force a four-byte field.
    a_r3_four_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_window[7] && in_window[15] && in_window[23])
            |-> ##2 (out_count == 3'd4));

    // R7: unsigned results never reach bits [31:29].
    a_r7_unsigned_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed) |-> ##2 (out_value[31:29] == 3'b000));

    // R4: unsigned four-byte value is the little-endian packing.
    a_r4_pack_order: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && in_window[7] && in_window[15] && in_window[23])
            |-> ##2 (out_value == {3'b000, $past(in_window[31:24], 2),
                                   $past(in_window[22:16], 2),
                                   $past(in_window[14:8], 2),
                                   $past(in_window[6:0], 2)}));

endmodule

bind varint_dec varint_dec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_signed(in_signed),
    .in_window(in_window),
    .out_valid(out_valid),
    .out_value(out_value),
    .out_count(out_count)
);

// File: tb/sim_varint_dec.sv
// Directed bench for varint_dec: one task per scenario, each checking
// its own results at the falling edge, two cycles after each request.
module sim_varint_dec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_signed = 1'b0;
    logic [31:0] in_window = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_value;
    logic [2:0]  out_count;

    int n_checks = 0;
    int n_fail   = 0;

    // Request queue for one back-to-back run.
    logic [31:0] q_w [256];
    logic        q_s [256];
    logic [31:0] q_v [256];
    logic [2:0]  q_c [256];
    string       q_tag [256];
    int          q_n = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;  // 250 MHz

    varint_dec u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_signed(in_signed),
        .in_window(in_window),
        .out_valid(out_valid),
        .out_value(out_value),
        .out_count(out_count)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected result computed from the requirements.
    task automatic ref_dec(input logic [31:0] w, input logic sg,
                           output logic [31:0] v, output logic [2:0] c);
        int top;
        v = '0; c = 3'd4; top = 28;
        for (int b = 0; b < 3; b++) begin
            v = v | ({25'd0, w[b*8 +: 7]} << (7*b));
            if (!w[b*8+7]) begin
                c = 3'(b + 1); top = 7*b + 6;
                break;
            end
        end
        if (c == 3'd4) v = v | ({24'd0, w[31:24]} << 21);
        if (sg && v[top]) v = v | (32'hFFFF_FFFF << (top + 1));
    endtask

    task automatic push(logic [31:0] w, logic sg, logic [31:0] ev,
                        logic [2:0] ec, string tag);
        q_w[q_n] = w; q_s[q_n] = sg; q_v[q_n] = ev; q_c[q_n] = ec;
        q_tag[q_n] = tag; q_n++;
    endtask

    // Drive the queue back to back and check each result two cycles on.
    task automatic run_seq();
        for (int t = 0; t < q_n + 2; t++) begin
            @(negedge clk);
            if (t >= 2) begin
                chk({q_tag[t-2], " valid"}, {31'd0, out_valid}, 32'd1);
                chk({q_tag[t-2], " value"}, out_value, q_v[t-2]);
                chk({q_tag[t-2], " count"}, {29'd0, out_count}, {29'd0, q_c[t-2]});
            end
            if (t < q_n) begin
                in_valid = 1'b1; in_window = q_w[t]; in_signed = q_s[t];
            end else begin
                in_valid = 1'b0;
            end
        end
        q_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R5 in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_lengths();
        push(32'hFFFF_FF05, 1'b0, 32'h0000_0005, 3'd1, "R2 one byte, junk after");
        push(32'hAABB_0181, 1'b0, 32'h0000_0081, 3'd2, "R1 two bytes");
        push(32'hEE7F_FFFF, 1'b0, 32'h001F_FFFF, 3'd3, "R1 three bytes");
        push(32'hFFFF_FFFF, 1'b0, 32'h1FFF_FFFF, 3'd4, "R3 max 29-bit");
        push(32'h0180_8080, 1'b0, 32'h0020_0000, 3'd4, "R3 fourth flag clear");
        push(32'h0483_8281, 1'b0, 32'h0080_C101, 3'd4, "R4 little-endian order");
        run_seq();
    endtask

    task automatic t_signed();
        push(32'hFFFF_FF40, 1'b1, 32'hFFFF_FFC0, 3'd1, "R8 sign bit 6");
        push(32'hFFFF_FF3F, 1'b1, 32'h0000_003F, 3'd1, "R8 positive 1 byte");
        push(32'hFFFF_4080, 1'b1, 32'hFFFF_E000, 3'd2, "R8 sign bit 13");
        push(32'hFF40_8080, 1'b1, 32'hFFF0_0000, 3'd3, "R8 sign bit 20");
        push(32'h8080_8080, 1'b1, 32'hF000_0000, 3'd4, "R8 sign bit 28");
        push(32'h8080_8080, 1'b0, 32'h1000_0000, 3'd4, "R7 zero-extend bit 28");
        push(32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 3'd4, "R8 all ones");
        push(32'hFFFF_FF40, 1'b0, 32'h0000_0040, 3'd1, "R10 mode flips back");
        run_seq();
    endtask

    // Single requests: result present at exactly t+2, gone at t+3.
    task automatic t_latency(logic [31:0] w, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_window = w; in_signed = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R5 t+1 ", tag}, {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk({"R5 t+2 ", tag}, {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        chk({"R5 t+3 ", tag}, {31'd0, out_valid}, 32'd0);
    endtask

    // Reset right after a request suppresses its result.
    task automatic t_mid_reset();
        @(negedge clk);
        in_valid = 1'b1; in_window = 32'h0000_0011;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 flushed t+2", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R9 flushed t+3", {31'd0, out_valid}, 32'd0);
    endtask

    // Back-to-back pseudo-random requests against the reference.
    task automatic t_random();
        logic [31:0] ev;
        logic [2:0]  ec;
        for (int i = 0; i < 200; i++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ref_dec(rng, rng[3] ^ rng[12], ev, ec);
            push(rng, rng[3] ^ rng[12], ev, ec, "R10 random stream");
        end
        run_seq();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R5 watchdog expired: got hang expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_lengths();
        t_signed();
        t_latency(32'h0000_0001, "len1");
        t_latency(32'h0180_8080, "len4");
        t_mid_reset();
        t_random();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule